// File: doc/BRIEF.md
# Interleaved I/Q Input Formatter

This block sits at the front of a transmit datapath. It takes 16-bit sample words from two parallel input buses, or from a single bus that carries I and Q words in turn. It turns them into aligned I/Q pairs in an internal signed format. Each pair is registered and marked by a one-cycle valid strobe. A transmit enable gates the whole path. While the enable is low the outputs hold mid-scale.

Configuration inputs control the following:
- selection between two-bus and one-bus operation;
- how the I/Q phase of the single bus is recovered: from the enable edge, or from a per-word flag pin;
- whether input words are two's complement or offset binary;
- whether the B bus is wired with its bit order reversed;
- whether the input words are replaced by an internal ramp, for bring-up.

Top module: `iq_input_formatter`

## Requirements
- R1: While reset is asserted, out_i and out_q are 0 and out_valid is 0.
- R2: With cfg_interleave low and tx_en high at a clock edge, the pair (I from bus A, Q from bus B) appears on out_i/out_q after that edge with out_valid high, one register stage of latency.
- R3: With cfg_interleave high, bus_b has no effect on out_i, out_q or out_valid.
- R4: With cfg_interleave high and cfg_qflag_mode low, the first bus A word captured at an edge where tx_en is high after being low is I. Later words alternate Q, I, Q and so on. The I word is held inside the block, and out_valid pulses once per pair, after the edge that captures the Q word. On other edges out_valid is 0 and out_i/out_q keep their previous values.
- R5: With cfg_interleave high and cfg_qflag_mode high, a word captured while q_flag is 1 is Q, and it is paired with the most recent I word. A word captured while q_flag is 0 is I and produces no strobe. The held I word is 0 if no I word has arrived since tx_en was last low.
- R6: An edge where tx_en is low drives out_i and out_q to 0 (signed mid-scale) and out_valid to 0. It also clears the held I word and the alternation phase.
- R7: With cfg_twos low, input words are offset binary and are converted by inverting bit 15. Input 0x0000 therefore becomes 0x8000, full-scale negative.
- R8: With cfg_twos high, input words pass unchanged.
- R9: With cfg_rev_b high, bus_b bit 15 is taken as the LSB and bit 0 as the MSB, so the word used is bus_b bit-reversed. Bus A is never reversed.
- R10: With cfg_ramp high, an internal 16-bit ramp replaces the pin data on both lanes. The ramp is not bit-reversed, and the format conversion of R7/R8 still applies. The ramp advances by 1 on each edge where tx_en is high, wraps from 0xFFFF to 0x0000, and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_a | input | 16 | Input bus A (I, or both I and Q when interleaved) |
| bus_b | input | 16 | Input bus B (Q in two-bus mode) |
| tx_en | input | 1 | Transmit enable; low forces mid-scale output |
| q_flag | input | 1 | Per-word Q marker used in flag phase mode |
| cfg_interleave | input | 1 | 1: both streams on bus A |
| cfg_qflag_mode | input | 1 | 1: phase from q_flag; 0: phase from tx_en edge |
| cfg_twos | input | 1 | 1: two's complement input; 0: offset binary |
| cfg_rev_b | input | 1 | 1: bus B bit order reversed |
| cfg_ramp | input | 1 | 1: internal ramp replaces input data |
| out_i | output | 16 | Registered I sample, signed |
| out_q | output | 16 | Registered Q sample, signed |
| out_valid | output | 1 | One-cycle strobe per delivered pair |

## Verification
The hardest state to reach is the ramp wrap from 0xFFFF to 0x0000. The ramp is cleared only by reset, so the only way there is to keep tx_en high in ramp mode for 65,536 consecutive captures. The stimulus does exactly that, with every produced pair compared along the way. The ramp test then continues in offset-binary, reversed-B and interleaved settings to show that the ramp skips reversal but not conversion. A second awkward case is dropping tx_en in the middle of a pair. The stimulus does this on purpose to show that the held I word is discarded and the next word is taken as I again.

// File: rtl/iqfmt_pkg.sv
package iqfmt_pkg;
  localparam int unsigned IQFMT_DEF_W = 16;

  typedef enum logic {
    LANE_I = 1'b0,
    LANE_Q = 1'b1
  } lane_e;
endpackage

// File: rtl/iqfmt_source.sv
module iqfmt_source #(
  parameter int unsigned W = iqfmt_pkg::IQFMT_DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_en,
  input  logic [W-1:0] bus_a,
  input  logic [W-1:0] bus_b,
  input  logic         cfg_twos,
  input  logic         cfg_rev_b,
  input  logic         cfg_ramp,
  output logic [W-1:0] smp_a,
  output logic [W-1:0] smp_b,
  output logic [W-1:0] ramp_val
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] ramp_q;
  logic [W-1:0] b_swapped;
  logic [W-1:0] b_word;
  logic [W-1:0] raw_a;
  logic [W-1:0] raw_b;

  function automatic logic [W-1:0] to_internal(input logic [W-1:0] raw, input logic twos);
    logic [W-1:0] r;
    r = raw;
    if (!twos) r[MSB] = ~raw[MSB];
    return r;
  endfunction

  for (genvar k = 0; k < W; k++) begin : g_swap
    assign b_swapped[k] = bus_b[MSB-k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                ramp_q <= '0;
    else if (tx_en && cfg_ramp) ramp_q <= ramp_q + 1'b1;
  end

  always_comb begin
    b_word = cfg_rev_b ? b_swapped : bus_b;
    raw_a  = cfg_ramp ? ramp_q : bus_a;
    raw_b  = cfg_ramp ? ramp_q : b_word;
    smp_a  = to_internal(raw_a, cfg_twos);
    smp_b  = to_internal(raw_b, cfg_twos);
  end

  assign ramp_val = ramp_q;
endmodule

// File: rtl/iqfmt_phase.sv
module iqfmt_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic cfg_interleave,
  input  logic cfg_qflag_mode,
  input  logic q_flag,
  output logic cur_is_q
);
  import iqfmt_pkg::*;

  lane_e next_lane_q;
  lane_e cur_lane;

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) next_lane_q <= LANE_I;
    else if (cfg_interleave) next_lane_q <= (next_lane_q == LANE_I) ? LANE_Q : LANE_I;
  end

  always_comb begin
    if (cfg_qflag_mode) cur_lane = q_flag ? LANE_Q : LANE_I;
    else                cur_lane = next_lane_q;
  end

  assign cur_is_q = (cur_lane == LANE_Q);
endmodule

// File: rtl/iqfmt_pair.sv
module iqfmt_pair #(
  parameter int unsigned W = iqfmt_pkg::IQFMT_DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_en,
  input  logic         cfg_interleave,
  input  logic         cur_is_q,
  input  logic [W-1:0] smp_a,
  input  logic [W-1:0] smp_b,
  output logic         cap_i,
  output logic         cap_q,
  output logic [W-1:0] out_i,
  output logic [W-1:0] out_q,
  output logic         out_valid
);
  logic [W-1:0] held_i;

  assign cap_i = tx_en && cfg_interleave && !cur_is_q;
  assign cap_q = tx_en && cfg_interleave && cur_is_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) held_i <= '0;
    else if (cap_i)       held_i <= smp_a;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) begin
      out_i     <= '0;
      out_q     <= '0;
      out_valid <= 1'b0;
    end else if (!cfg_interleave) begin
      out_i     <= smp_a;
      out_q     <= smp_b;
      out_valid <= 1'b1;
    end else if (cap_q) begin
      out_i     <= held_i;
      out_q     <= smp_a;
      out_valid <= 1'b1;
    end else begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/iq_input_formatter.sv
module iq_input_formatter #(
  parameter int unsigned SAMPLE_W = iqfmt_pkg::IQFMT_DEF_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] bus_a,
  input  logic [SAMPLE_W-1:0] bus_b,
  input  logic                tx_en,
  input  logic                q_flag,
  input  logic                cfg_interleave,
  input  logic                cfg_qflag_mode,
  input  logic                cfg_twos,
  input  logic                cfg_rev_b,
  input  logic                cfg_ramp,
  output logic [SAMPLE_W-1:0] out_i,
  output logic [SAMPLE_W-1:0] out_q,
  output logic                out_valid
);
  logic [SAMPLE_W-1:0] smp_a;
  logic [SAMPLE_W-1:0] smp_b;
  logic [SAMPLE_W-1:0] ramp_val;
  logic                cur_is_q;
  logic                cap_i;
  logic                cap_q;

  iqfmt_source #(.W(SAMPLE_W)) u_source (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
    .bus_a(bus_a), .bus_b(bus_b),
    .cfg_twos(cfg_twos), .cfg_rev_b(cfg_rev_b), .cfg_ramp(cfg_ramp),
    .smp_a(smp_a), .smp_b(smp_b), .ramp_val(ramp_val)
  );

  iqfmt_phase u_phase (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
    .cfg_interleave(cfg_interleave), .cfg_qflag_mode(cfg_qflag_mode),
    .q_flag(q_flag), .cur_is_q(cur_is_q)
  );

  iqfmt_pair #(.W(SAMPLE_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
    .cfg_interleave(cfg_interleave), .cur_is_q(cur_is_q),
    .smp_a(smp_a), .smp_b(smp_b),
    .cap_i(cap_i), .cap_q(cap_q),
    .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
  );
endmodule

// File: rtl/iqfmt_chk.sv
module iqfmt_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tx_en,
  input logic         cfg_interleave,
  input logic         cfg_qflag_mode,
  input logic         cfg_ramp,
  input logic         cap_i,
  input logic         cap_q,
  input logic [W-1:0] smp_a,
  input logic [W-1:0] ramp_val,
  input logic [W-1:0] out_i,
  input logic [W-1:0] out_q,
  input logic         out_valid
);
  // R6
  txoff_midscale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!out_valid && out_i == '0 && out_q == '0));

  // R2
  direct_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !cfg_interleave) |=> out_valid);

  // R4
  pair_on_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q |=> (out_valid && out_q == $past(smp_a)));

  // R4
  no_strobe_on_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (!out_valid && $stable(out_i) && $stable(out_q)));

  // R4
  toggle_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_q && !cfg_qflag_mode) |=> (cfg_qflag_mode || !cap_q));

  // R10
  ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && cfg_ramp) |=> (ramp_val == W'($past(ramp_val) + 1'b1)));

  // R10
  ramp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_en && cfg_ramp) |=> $stable(ramp_val));
endmodule

bind iq_input_formatter iqfmt_chk #(.W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
  .cfg_interleave(cfg_interleave), .cfg_qflag_mode(cfg_qflag_mode), .cfg_ramp(cfg_ramp),
  .cap_i(cap_i), .cap_q(cap_q), .smp_a(smp_a), .ramp_val(ramp_val),
  .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
);

// File: tb/test_iq_input_formatter.sv
module test_iq_input_formatter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_a = '0, bus_b = '0;
  logic        tx_en = 1'b0, q_flag = 1'b0;
  logic        cfg_interleave = 1'b0, cfg_qflag_mode = 1'b0, cfg_twos = 1'b0;
  logic        cfg_rev_b = 1'b0, cfg_ramp = 1'b0;
  logic [15:0] out_i, out_q;
  logic        out_valid;

  // pending configuration, applied at the next drive
  logic t_inter = 0, t_qmode = 0, t_twos = 0, t_rev = 0, t_ramp = 0;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    logic        v;
    logic [15:0] i;
    logic [15:0] q;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  // bench model state
  logic [15:0] m_ramp = 0, m_hold = 0, m_oi = 0, m_oq = 0;
  logic        m_phase = 0, m_v = 0;

  always #10 clk = ~clk;

  iq_input_formatter i_iq_input_formatter (
    .clk(clk), .rst_n(rst_n), .bus_a(bus_a), .bus_b(bus_b),
    .tx_en(tx_en), .q_flag(q_flag),
    .cfg_interleave(cfg_interleave), .cfg_qflag_mode(cfg_qflag_mode),
    .cfg_twos(cfg_twos), .cfg_rev_b(cfg_rev_b), .cfg_ramp(cfg_ramp),
    .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
  );

  function automatic logic [15:0] fmt(input logic [15:0] w, input logic twos);
    return twos ? w : (w ^ 16'h8000);
  endfunction

  function automatic logic [15:0] mirror(input logic [15:0] w);
    logic [15:0] r;
    for (int k = 0; k < 16; k++) r[15-k] = w[k];
    return r;
  endfunction

  task automatic drive(input logic [15:0] a, input logic [15:0] b,
                       input logic tx, input logic qf, input string tag);
    logic [15:0] ra, rb;
    exp_t e;
    @(negedge clk);
    cfg_interleave = t_inter; cfg_qflag_mode = t_qmode; cfg_twos = t_twos;
    cfg_rev_b = t_rev; cfg_ramp = t_ramp;
    bus_a = a; bus_b = b; tx_en = tx; q_flag = qf;
    if (!tx) begin
      m_oi = 0; m_oq = 0; m_v = 0; m_phase = 0; m_hold = 0;
    end else begin
      ra = t_ramp ? m_ramp : a;
      rb = t_ramp ? m_ramp : (t_rev ? mirror(b) : b);
      if (t_ramp) m_ramp = m_ramp + 16'd1;
      if (!t_inter) begin
        m_oi = fmt(ra, t_twos); m_oq = fmt(rb, t_twos); m_v = 1;
      end else begin
        logic isq;
        isq = t_qmode ? qf : m_phase;
        m_phase = ~m_phase;
        if (isq) begin
          m_oi = m_hold; m_oq = fmt(ra, t_twos); m_v = 1;
        end else begin
          m_hold = fmt(ra, t_twos); m_v = 0;
        end
      end
    end
    e.v = m_v; e.i = m_oi; e.q = m_oq; e.tag = tag;
    sbq.push_back(e);
  endtask

  // monitor: compares one expected item per cycle, after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        n_run++;
        if (out_valid !== e.v || out_i !== e.i || out_q !== e.q) begin
          n_fail++;
          $display("FAIL %s: got v=%0b i=%h q=%h, expected v=%0b i=%h q=%h",
                   e.tag, out_valid, out_i, out_q, e.v, e.i, e.q);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    n_run++;
    if (out_valid !== 1'b0 || out_i !== 16'h0 || out_q !== 16'h0) begin
      n_fail++;
      $display("FAIL R1: got v=%0b i=%h q=%h, expected v=0 i=0000 q=0000", out_valid, out_i, out_q);
    end
    rst_n = 1'b1;

    // R6: idle with tx_en low
    drive(16'h1111, 16'h2222, 0, 0, "R6 idle");
    drive(16'h3333, 16'h4444, 0, 0, "R6 idle");

    // R2, R7: two-bus offset binary
    drive(16'h0000, 16'h0000, 1, 0, "R7 zero is full-scale negative");
    drive(16'hFFFF, 16'h8000, 1, 0, "R7 full-scale positive / mid");
    drive(16'h1234, 16'hABCD, 1, 0, "R2 direct pair");
    drive(16'h7FFF, 16'h0001, 1, 0, "R2 direct pair");

    // R8: two's complement pass-through
    t_twos = 1;
    drive(16'h8000, 16'h7FFF, 1, 0, "R8 pass-through");
    drive(16'h5A5A, 16'hC3C3, 1, 0, "R8 pass-through");

    // R9: B bit reversal
    t_rev = 1;
    drive(16'h0001, 16'h0001, 1, 0, "R9 bit0 becomes MSB");
    drive(16'h0001, 16'h8000, 1, 0, "R9 bit15 becomes LSB");
    drive(16'h00F0, 16'h1234, 1, 0, "R9 pattern, A unreversed");
    t_rev = 0;

    // R6: tx low in the middle of streaming
    drive(16'h4321, 16'h8765, 0, 0, "R6 forced mid-scale");

    // R3, R4: interleaved, edge-derived phase, bus_b randomized
    t_inter = 1;
    for (int n = 0; n < 8; n++)
      drive(16'h0100 + 16'(n), 16'($urandom), 1, 0, "R4 alternating I/Q, R3 bus B ignored");
    // drop tx in the middle of a pair, then restart
    drive(16'h0AAA, 16'($urandom), 1, 0, "R4 lone I");
    drive(16'h0BBB, 16'($urandom), 0, 0, "R6 drop mid-pair");
    drive(16'h0CCC, 16'($urandom), 1, 0, "R4 realign I after drop");
    drive(16'h0DDD, 16'($urandom), 1, 0, "R4 realign Q after drop");
    t_twos = 0;
    drive(16'h0000, 16'($urandom), 1, 0, "R7 interleaved I");
    drive(16'hFFFF, 16'($urandom), 1, 0, "R7 interleaved Q");

    // R5: flag-derived phase
    t_qmode = 1; t_twos = 1;
    drive(16'h0000, 16'h0, 0, 0, "R6 gap");
    drive(16'h2001, 16'($urandom), 1, 1, "R5 Q before any I");
    drive(16'h2002, 16'($urandom), 1, 0, "R5 I");
    drive(16'h2003, 16'($urandom), 1, 0, "R5 I replaces I");
    drive(16'h2004, 16'($urandom), 1, 1, "R5 Q pairs latest I");
    drive(16'h2005, 16'($urandom), 1, 1, "R5 Q reuses held I");
    drive(16'h2006, 16'($urandom), 1, 0, "R5 I");
    drive(16'h2007, 16'($urandom), 1, 1, "R5 Q");

    // R10: ramp, through the wrap
    t_inter = 0; t_qmode = 0; t_twos = 1;
    drive(16'h0, 16'h0, 0, 0, "R6 gap");
    t_ramp = 1;
    for (int n = 0; n < 65540; n++)
      drive(16'($urandom), 16'($urandom), 1, 0, "R10 ramp through wrap");
    drive(16'h0, 16'h0, 0, 0, "R10 ramp holds while tx low");
    t_twos = 0; t_rev = 1;
    for (int n = 0; n < 4; n++)
      drive(16'($urandom), 16'($urandom), 1, 0, "R10 ramp offset-binary, not reversed");
    t_inter = 1;
    for (int n = 0; n < 4; n++)
      drive(16'($urandom), 16'($urandom), 1, 0, "R10 ramp interleaved");
    t_ramp = 0; t_rev = 0; t_inter = 0;
    drive(16'h0, 16'h0, 0, 0, "R6 final idle");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule